// File: doc/BRIEF.md
# Native Command Queue Tag Tracker

This block sits on the host side of a serial storage link and manages up to 32 queued read and write commands in flight at once. A client hands it a command (start LBA, sector count, direction). The tracker picks a free 5-bit tag and asks the transmit side to send a host-to-device register frame that carries that tag. It then waits for the device's register acknowledge, which marks the tag as queued. After that acknowledge the next command may be accepted, without waiting for any data movement.

The device then drives the data phases in whatever order it likes. The received-frame port feeds the tracker a simplified view of each incoming frame: its type, a tag and a 32-bit bitmap. A DMA Setup opens a data phase for the named tag. The tracker presents that tag and its direction so the data path can select the right buffer. For a write, the host may send data only once the device's DMA Activate arrives. A Set Device Bits frame retires every queued tag whose bit is set, and it closes the current phase. Frames that name tags that are not queued raise a sticky protocol-error flag and change nothing else.

Top module: `ncq_tracker`

## Requirements
- R1: After reset, cmd_ready is 1, while queued_mask, tx_valid, xfer_active, xfer_send and proto_err are all 0.
- R2: While cmd_ready is 1, cmd_tag shows the lowest-numbered tag that is neither queued nor awaiting acknowledge, and an accepted command receives that tag.
- R3: The cycle after a command is accepted (cmd_valid and cmd_ready high at a clock edge), tx_valid rises with tx_tag, tx_lba, tx_count and tx_write equal to the accepted values. These outputs hold steady until a clock edge where tx_ready is 1, after which tx_valid is 0.
- R4: From acceptance until a received frame of type 0 (device register acknowledge) arrives, cmd_ready is 0. After that frame, the bit of the tag in queued_mask is 1.
- R5: When all 32 tags are queued, cmd_ready is 0.
- R6: A received frame of type 1 (DMA Setup) whose rx_tag is queued sets xfer_active on the next cycle, with xfer_tag equal to that tag and xfer_write equal to the direction of that command (1 = write).
- R7: A received frame of type 2 (DMA Activate) during an active write phase sets xfer_send. During a read phase, or with no phase active, it leaves xfer_send at 0.
- R8: A received frame of type 4 (Set Device Bits) clears every queued_mask bit whose rx_bits bit is 1, and it clears xfer_active and xfer_send. A frame of type 3 (data) changes no output.
- R9: A DMA Setup naming a tag that is not queued, or a Set Device Bits with a 1 in a non-queued position, sets proto_err, which stays 1 until reset. The DMA Setup leaves the phase outputs and queued_mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Tracker can accept a command |
| cmd_lba | input | 48 | Start sector address |
| cmd_count | input | 16 | Sector count |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_tag | output | 5 | Tag the next accepted command receives |
| tx_valid | output | 1 | Register frame ready to transmit |
| tx_ready | input | 1 | Transmitter takes the frame |
| tx_tag | output | 5 | Tag carried in the frame |
| tx_lba | output | 48 | Sector address for the frame |
| tx_count | output | 16 | Sector count for the frame |
| tx_write | output | 1 | Direction for the frame |
| rx_valid | input | 1 | Received frame present (one cycle) |
| rx_type | input | 3 | 0 reg ack, 1 DMA Setup, 2 DMA Activate, 3 data, 4 Set Device Bits |
| rx_tag | input | 5 | Tag field of DMA Setup |
| rx_bits | input | 32 | Completion bitmap of Set Device Bits |
| queued_mask | output | 32 | One bit per queued tag |
| xfer_active | output | 1 | Data phase open |
| xfer_tag | output | 5 | Tag of the open phase |
| xfer_write | output | 1 | Direction of the open phase |
| xfer_send | output | 1 | Host may send write data |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The hardest state to reach is a full queue. Getting there takes 32 complete accept, transmit and acknowledge handshakes with no retirement in between. The stimulus therefore runs a directed fill loop after the random phase and then drains the whole queue with a single all-ones completion bitmap. Out-of-order service is exercised by a random phase that picks queued tags at random and retires them, sometimes together with extra queued bits in the same bitmap. The error paths come last, because the error flag is sticky.

// File: rtl/ncq_pkg.sv
// Shared encodings for the queued command tracker.
package ncq_pkg;
    typedef enum logic [2:0] {
        FT_REG_ACK   = 3'd0,
        FT_DMA_SETUP = 3'd1,
        FT_DMA_ACT   = 3'd2,
        FT_DATA      = 3'd3,
        FT_SDB       = 3'd4
    } frame_t;
endpackage

// File: rtl/ncq_tag_alloc.sv
// Lowest-free tag finder.
// Assumes: busy has one bit per tag; any_free is 0 when every bit is set.
module ncq_tag_alloc #(
    parameter int TAGS  = 32,
    parameter int TAG_W = $clog2(TAGS)
) (
    input  logic [TAGS-1:0]  busy,
    output logic [TAG_W-1:0] free_tag,
    output logic             any_free
);
    // Scan from the top so the lowest free index wins.
    always_comb begin
        free_tag = '0;
        any_free = 1'b0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_tag = TAG_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ncq_slot_table.sv
// Per-tag state: allocated, queued, and direction.
// Assumes: the caller allocates only free tags and acknowledges only the pending tag.
module ncq_slot_table #(
    parameter int TAGS  = 32,
    parameter int TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             alloc_dir,
    input  logic             ack_en,
    input  logic [TAG_W-1:0] ack_tag,
    input  logic [TAGS-1:0]  retire,
    output logic [TAGS-1:0]  busy,
    output logic [TAGS-1:0]  queued,
    output logic [TAGS-1:0]  dir
);
    for (genvar g = 0; g < TAGS; g++) begin : g_slot
        // One slot: set on allocate or acknowledge, cleared on retire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[g]   <= 1'b0;
                queued[g] <= 1'b0;
                dir[g]    <= 1'b0;
            end else begin
                if (alloc_en && alloc_tag == TAG_W'(g)) begin
                    busy[g] <= 1'b1;
                    dir[g]  <= alloc_dir;
                end
                if (ack_en && ack_tag == TAG_W'(g)) begin
                    queued[g] <= 1'b1;
                end
                if (retire[g]) begin
                    busy[g]   <= 1'b0;
                    queued[g] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ncq_phase_ctrl.sv
// Tracks the single device-driven data phase currently open.
// Assumes: open_en is raised only for a queued tag; close_en marks completion.
module ncq_phase_ctrl #(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [TAG_W-1:0] open_tag,
    input  logic             open_write,
    input  logic             activate,
    input  logic             close_en,
    output logic             active,
    output logic [TAG_W-1:0] tag,
    output logic             write,
    output logic             send
);
    // Open, grant write data, or close the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tag    <= '0;
            write  <= 1'b0;
            send   <= 1'b0;
        end else if (close_en) begin
            active <= 1'b0;
            send   <= 1'b0;
        end else if (open_en) begin
            active <= 1'b1;
            tag    <= open_tag;
            write  <= open_write;
            send   <= 1'b0;
        end else if (activate && active && write) begin
            send <= 1'b1;
        end
    end
endmodule

// File: rtl/ncq_tracker.sv
// Host-side queued command tracker: allocates tags, issues register frames,
// follows device-chosen data phases and retires tags from completion bitmaps.
// Assumes: rx frames are single-cycle pulses; payload and link layers are external.
module ncq_tracker #(
    parameter int TAGS  = 32,
    parameter int LBA_W = 48,
    parameter int CNT_W = 16,
    localparam int TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [LBA_W-1:0] cmd_lba,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             cmd_write,
    output logic [TAG_W-1:0] cmd_tag,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [TAG_W-1:0] tx_tag,
    output logic [LBA_W-1:0] tx_lba,
    output logic [CNT_W-1:0] tx_count,
    output logic             tx_write,
    input  logic             rx_valid,
    input  logic [2:0]       rx_type,
    input  logic [TAG_W-1:0] rx_tag,
    input  logic [TAGS-1:0]  rx_bits,
    output logic [TAGS-1:0]  queued_mask,
    output logic             xfer_active,
    output logic [TAG_W-1:0] xfer_tag,
    output logic             xfer_write,
    output logic             xfer_send,
    output logic             proto_err
);
    import ncq_pkg::*;

    logic [TAGS-1:0]  busy, queued, dir;
    logic [TAG_W-1:0] free_tag;
    logic             any_free, await_q, accept;
    logic             is_ack, is_setup, is_act, is_sdb;
    logic             setup_ok, setup_bad, sdb_bad;
    logic [TAGS-1:0]  retire;

    ncq_tag_alloc #(.TAGS(TAGS), .TAG_W(TAG_W)) u_alloc (
        .busy(busy), .free_tag(free_tag), .any_free(any_free)
    );

    // Frame decode and error classification.
    always_comb begin
        is_ack    = rx_valid && rx_type == FT_REG_ACK;
        is_setup  = rx_valid && rx_type == FT_DMA_SETUP;
        is_act    = rx_valid && rx_type == FT_DMA_ACT;
        is_sdb    = rx_valid && rx_type == FT_SDB;
        setup_ok  = is_setup && queued[rx_tag];
        setup_bad = is_setup && !queued[rx_tag];
        sdb_bad   = is_sdb && |(rx_bits & ~queued);
        retire    = is_sdb ? (rx_bits & queued) : '0;
    end

    assign cmd_ready   = any_free && !await_q;
    assign cmd_tag     = free_tag;
    assign accept      = cmd_valid && cmd_ready;
    assign queued_mask = queued;

    ncq_slot_table #(.TAGS(TAGS), .TAG_W(TAG_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(accept), .alloc_tag(free_tag), .alloc_dir(cmd_write),
        .ack_en(is_ack && await_q), .ack_tag(tx_tag),
        .retire(retire),
        .busy(busy), .queued(queued), .dir(dir)
    );

    ncq_phase_ctrl #(.TAG_W(TAG_W)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .open_en(setup_ok), .open_tag(rx_tag), .open_write(dir[rx_tag]),
        .activate(is_act), .close_en(is_sdb),
        .active(xfer_active), .tag(xfer_tag), .write(xfer_write), .send(xfer_send)
    );

    // Issue path: latch the accepted command and hold it until transmitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_tag   <= '0;
            tx_lba   <= '0;
            tx_count <= '0;
            tx_write <= 1'b0;
        end else if (accept) begin
            tx_valid <= 1'b1;
            tx_tag   <= free_tag;
            tx_lba   <= cmd_lba;
            tx_count <= cmd_count;
            tx_write <= cmd_write;
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // Acknowledge wait: blocks new commands until the device confirms queuing.
    always_ff @(posedge clk) begin
        if (!rst_n)      await_q <= 1'b0;
        else if (accept) await_q <= 1'b1;
        else if (is_ack) await_q <= 1'b0;
    end

    // Sticky protocol error.
    always_ff @(posedge clk) begin
        if (!rst_n)                      proto_err <= 1'b0;
        else if (setup_bad || sdb_bad)   proto_err <= 1'b1;
    end
endmodule

// File: rtl/ncq_tracker_chk.sv
// Protocol checker for ncq_tracker, attached by bind.
module ncq_tracker_chk #(
    parameter int TAGS  = 32,
    parameter int TAG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [TAG_W-1:0] tx_tag,
    input logic             rx_valid,
    input logic [2:0]       rx_type,
    input logic [TAGS-1:0]  rx_bits,
    input logic [TAGS-1:0]  queued_mask,
    input logic             xfer_active,
    input logic [TAG_W-1:0] xfer_tag,
    input logic             xfer_write,
    input logic             xfer_send,
    input logic             proto_err
);
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_tag));
    a_r4_no_accept_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !cmd_ready);
    a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (&queued_mask) |-> !cmd_ready);
    a_r6_phase_queued: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> queued_mask[xfer_tag]);
    a_r7_send_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_send |-> xfer_active && xfer_write);
    a_r8_sdb_retires: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_type == 3'd4 |=> (queued_mask & $past(rx_bits)) == '0 && !xfer_active);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind ncq_tracker ncq_tracker_chk #(.TAGS(TAGS), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_tag(tx_tag),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_bits(rx_bits),
    .queued_mask(queued_mask), .xfer_active(xfer_active), .xfer_tag(xfer_tag),
    .xfer_write(xfer_write), .xfer_send(xfer_send), .proto_err(proto_err)
);

// File: tb/tb_ncq_tracker.sv
`timescale 1ns/1ps
module tb_ncq_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [47:0] cmd_lba = '0;
    logic [15:0] cmd_count = '0;
    logic        cmd_ready;
    logic [4:0]  cmd_tag;
    logic        tx_valid, tx_write;
    logic        tx_ready = 1'b0;
    logic [4:0]  tx_tag;
    logic [47:0] tx_lba;
    logic [15:0] tx_count;
    logic        rx_valid = 1'b0;
    logic [2:0]  rx_type = '0;
    logic [4:0]  rx_tag = '0;
    logic [31:0] rx_bits = '0;
    logic [31:0] queued_mask;
    logic        xfer_active, xfer_write, xfer_send, proto_err;
    logic [4:0]  xfer_tag;

    int checks = 0, fails = 0;
    logic [31:0] exp_q = '0;
    logic [31:0] exp_dir = '0;

    always #2.5 clk = ~clk;

    ncq_tracker dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] lowest_free(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (!m[i]) return 5'(i);
        return 5'd0;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_rx(input logic [2:0] t, input logic [4:0] tg, input logic [31:0] b);
        rx_valid = 1'b1; rx_type = t; rx_tag = tg; rx_bits = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic issue(input bit wr, input int hold);
        logic [47:0] l;
        logic [15:0] c;
        logic [4:0]  t;
        l = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        c = 16'($urandom);
        t = lowest_free(exp_q);
        chk(cmd_ready === 1'b1, "R2 ready", 64'(cmd_ready), 1);
        chk(cmd_tag === t, "R2 lowest tag", 64'(cmd_tag), 64'(t));
        cmd_valid = 1'b1; cmd_lba = l; cmd_count = c; cmd_write = wr;
        tick();
        cmd_valid = 1'b0;
        chk(tx_valid && tx_tag === t && tx_lba === l && tx_count === c && tx_write === wr,
            "R3 frame", {tx_valid, tx_write, tx_tag, tx_lba[31:0]}, {1'b1, wr, t, l[31:0]});
        chk(cmd_ready === 1'b0, "R4 ready low", 64'(cmd_ready), 0);
        for (int k = 0; k < hold; k++) begin
            tick();
            chk(tx_valid === 1'b1 && tx_tag === t, "R3 hold", 64'(tx_valid), 1);
        end
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
        chk(tx_valid === 1'b0, "R3 drop", 64'(tx_valid), 0);
        send_rx(3'd0, 5'd0, '0);
        exp_q[t] = 1'b1;
        exp_dir[t] = wr;
        chk(queued_mask === exp_q, "R4 queued", 64'(queued_mask), 64'(exp_q));
        chk(cmd_ready === !(&exp_q), "R4 ready back", 64'(cmd_ready), 64'(!(&exp_q)));
    endtask

    task automatic service(input logic [4:0] t, input logic [31:0] extra);
        logic [31:0] bm;
        send_rx(3'd1, t, '0);
        chk(xfer_active && xfer_tag === t && xfer_write === exp_dir[t], "R6 phase",
            {xfer_active, xfer_write, xfer_tag}, {1'b1, exp_dir[t], t});
        send_rx(3'd2, 5'd0, '0);
        chk(xfer_send === exp_dir[t], "R7 activate", 64'(xfer_send), 64'(exp_dir[t]));
        send_rx(3'd3, 5'd0, '0);
        chk(queued_mask === exp_q && xfer_active, "R8 data frame no effect",
            64'(queued_mask), 64'(exp_q));
        bm = (extra & exp_q) | (32'd1 << t);
        send_rx(3'd4, 5'd0, bm);
        exp_q = exp_q & ~bm;
        chk(queued_mask === exp_q && !xfer_active && !xfer_send, "R8 retire",
            64'(queued_mask), 64'(exp_q));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        exp_q = '0; exp_dir = '0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [4:0] t;
        void'($urandom(32'd1234));
        tick();
        do_reset();
        // R1 reset state
        chk(cmd_ready === 1 && queued_mask === 0 && tx_valid === 0 && xfer_active === 0
            && xfer_send === 0 && proto_err === 0, "R1 reset",
            {cmd_ready, tx_valid, xfer_active, xfer_send, proto_err, queued_mask}, 64'h1_0000_0000 << 4);
        // Directed: three commands, serve out of order
        issue(1'b1, 2);
        issue(1'b0, 0);
        issue(1'b1, 1);
        // R7 activate with no phase open does nothing
        send_rx(3'd2, 5'd0, '0);
        chk(xfer_send === 1'b0, "R7 activate idle", 64'(xfer_send), 0);
        service(5'd1, '0);
        service(5'd2, 32'h1);
        // Random mix
        for (int it = 0; it < 300; it++) begin
            if (exp_q == 0 || (!(&exp_q) && $urandom_range(0, 1) == 1)) begin
                issue(1'($urandom), $urandom_range(0, 2));
            end else begin
                do t = 5'($urandom); while (!exp_q[t]);
                service(t, ($urandom_range(0, 3) == 0) ? $urandom : 32'd0);
            end
        end
        // R5 fill to capacity
        while (!(&exp_q)) issue(1'($urandom), 0);
        tick();
        chk(cmd_ready === 1'b0, "R5 full", 64'(cmd_ready), 0);
        send_rx(3'd4, 5'd0, 32'hFFFF_FFFF);
        exp_q = '0;
        chk(queued_mask === 0 && cmd_ready === 1 && proto_err === 0, "R8 drain all",
            64'(queued_mask), 0);
        // R9 setup on free tag
        send_rx(3'd1, 5'd7, '0);
        chk(proto_err === 1 && xfer_active === 0 && queued_mask === 0, "R9 bad setup",
            {proto_err, xfer_active}, 2'b10);
        tick(); tick();
        chk(proto_err === 1, "R9 sticky", 64'(proto_err), 1);
        // R9 completion bit for a free tag
        do_reset();
        issue(1'b0, 0);
        send_rx(3'd4, 5'd0, 32'h0000_0003);
        chk(proto_err === 1 && queued_mask === 0, "R9 bad sdb",
            {proto_err, queued_mask}, 33'h1_0000_0000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule